// File: doc/BRIEF.md
# CAN Transmit Command and Status Control

This block sits between a host CPU and the protocol engine of a CAN controller and owns the transmit side of the command interface. The CPU writes a command byte in which three bits matter here: a transmit request, an abort, and a self-reception request. Their combinations choose whether a frame is retried after a failure and whether the frame is received back by its own sender. Reads of the command byte always return zero.

Toward the protocol engine the block holds a start request, qualified by single-shot and self-reception flags, until the engine reports that the frame went onto the bus. The engine then reports success, an error or lost arbitration. From these pulses the block keeps three status bits: transmit buffer free, last transmission complete, and frame on the bus. It also raises a sticky transmit interrupt. While the buffer is locked, CPU writes into the transmit byte array are dropped without any indication.

A request cancelled by an abort before it reaches the bus frees the buffer and still raises the interrupt. An abort that arrives after the frame has started does not stop it, but it removes any retry.

Top module: `can_tx_cmd_ctrl`

## Requirements
- R1: `cmdRdData` reads 0x00 at all times.
- R2: A command byte with bit 0 (request) or bit 4 (self-reception) set, written while `txBufFree`=1, gives `txStartReq`=1, `txBufFree`=0 and `txComplete`=0 one cycle later. With bit 4 alone, `txSelfRx`=1 and `txSingleShot`=0. A request written while `txBufFree`=0 changes neither `txSelfRx` nor `txSingleShot`.
- R3: Bit 1 (abort) written together with a request gives `txSingleShot`=1. Bits 4+1 give `txSelfRx`=1. Bits 0+1+4 give `txSelfRx`=0.
- R4: Bits 0+4 written without bit 1 give `txSelfRx`=0 and `txSingleShot`=0.
- R5: A `txStarted` pulse while `txStartReq`=1 gives `txStartReq`=0 and `txActive`=1 one cycle later.
- R6: A command with bit 1 alone, while `txStartReq`=1 and no `txStarted` arrives in that cycle, gives `txStartReq`=0, `txBufFree`=1 and `txIrq`=1 one cycle later. `txComplete` stays 0.
- R7: A command with bit 1 alone while `txActive`=1 leaves `txActive`=1. A later `txFail` or `txArbLost` then frees the buffer and does not retry.
- R8: A `txDone` pulse while `txActive`=1 gives `txActive`=0, `txComplete`=1, `txBufFree`=1 and `txIrq`=1. Reset gives `txBufFree`=1, `txComplete`=1, and `txStartReq`, `txActive` and `txIrq` all 0.
- R9: A `txFail` or `txArbLost` pulse while `txActive`=1 has two outcomes. When not single-shot, it gives `txStartReq`=1 again with the buffer still locked. When single-shot, it gives `txBufFree`=1 and `txIrq`=1, and `txComplete` stays 0.
- R10: A buffer write is stored only while `txBufFree`=1 and the address is below `BUF_BYTES`. Otherwise it is discarded. `bufRdData` returns the stored byte, and 0 for addresses at or above `BUF_BYTES`.
- R11: A command write in the cycle right after another command write cycle is ignored.
- R12: `txIrq` stays 1 until an `irqRdStrobe` cycle clears it. A set event in the same cycle as the strobe wins.
- R13: Bits 2, 3 and 5 to 7 of the command byte have no effect on the transmit path. A command with bit 0 and bit 4 both 0 never cancels a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWr | input | 1 | Command byte write strobe |
| cmdData | input | 8 | Command byte |
| cmdRdData | output | 8 | Command read value, always zero |
| bufWr | input | 1 | Transmit buffer write strobe |
| bufWrAddr | input | ADDR_W | Transmit buffer write address |
| bufWrData | input | DATA_W | Transmit buffer write byte |
| bufRdAddr | input | ADDR_W | Transmit buffer read address |
| bufRdData | output | DATA_W | Transmit buffer read byte |
| txStartReq | output | 1 | Frame waiting for the protocol engine |
| txSingleShot | output | 1 | No retry for the current frame |
| txSelfRx | output | 1 | Current frame is received back by the sender |
| txStarted | input | 1 | Engine pulse: frame went onto the bus |
| txDone | input | 1 | Engine pulse: frame sent successfully |
| txFail | input | 1 | Engine pulse: frame ended in an error |
| txArbLost | input | 1 | Engine pulse: arbitration lost |
| txBufFree | output | 1 | Transmit buffer released to the CPU |
| txComplete | output | 1 | Last requested frame completed successfully |
| txActive | output | 1 | Frame on the bus |
| txIrq | output | 1 | Sticky transmit interrupt |
| irqRdStrobe | input | 1 | CPU read of the interrupt register; clears `txIrq` |

## Verification
The bench builds the block with `BUF_BYTES`=13 and `DATA_W`=8. With these values the 4-bit address has three codes (13 to 15) that match no buffer entry, so writes to those codes are dropped and reads from them return zero. A byte-wide data path lets the bench write values that are easy to tell apart and check that a locked-buffer write does not overwrite the stored byte. The bench steps every command-bit combination through every transmit state. It also covers an abort arriving in the same cycle as a start, and back-to-back command writes.

// File: rtl/can_txc_pkg.sv
package can_txc_pkg;
  localparam int CMD_W     = 8;
  localparam int BIT_REQ   = 0;
  localparam int BIT_ABORT = 1;
  localparam int BIT_SELF  = 4;

  // decode -> control
  typedef struct packed {
    logic request;
    logic singleShot;
    logic selfRx;
    logic abort;
  } cmdStrobe_t;

  // control -> buffer datapath
  typedef struct packed {
    logic wrEn;
  } bufStrobe_t;
endpackage

// File: rtl/can_txc_decode.sv
module can_txc_decode
  import can_txc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWr,
  input  logic [CMD_W-1:0] cmdData,
  output cmdStrobe_t       strobes
);
  logic prevWr;
  logic live;
  logic anyReq;
  logic unusedCmdBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevWr <= 1'b0;
    else       prevWr <= cmdWr;
  end

  assign live          = cmdWr && !prevWr;
  assign anyReq        = cmdData[BIT_REQ] || cmdData[BIT_SELF];
  assign unusedCmdBits = ^{cmdData[7:5], cmdData[3:2]};

  always_comb begin
    strobes            = '0;
    strobes.request    = live && anyReq;
    strobes.singleShot = live && anyReq && cmdData[BIT_ABORT];
    strobes.selfRx     = live && cmdData[BIT_SELF] && !cmdData[BIT_REQ];
    strobes.abort      = live && cmdData[BIT_ABORT] && !anyReq;
  end

  // R11
  spacing_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    prevWr |-> (strobes == '0));

  // R4
  self_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData[BIT_REQ]) |-> !strobes.selfRx);
endmodule

// File: rtl/can_txc_ctrl.sv
module can_txc_ctrl
  import can_txc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cmdStrobe_t cmd,
  input  logic       txStarted,
  input  logic       txDone,
  input  logic       txFail,
  input  logic       txArbLost,
  input  logic       irqRdStrobe,
  input  logic       bufWr,
  output logic       txStartReq,
  output logic       txSingleShot,
  output logic       txSelfRx,
  output logic       txBufFree,
  output logic       txComplete,
  output logic       txActive,
  output logic       txIrq,
  output bufStrobe_t bufCtl
);
  logic pending, active, singleShot, selfRx, bufFree, complete, irq;
  logic nPending, nActive, nSingleShot, nSelfRx, nBufFree, nComplete, nIrq;
  logic irqSet;

  always_comb begin
    nPending    = pending;
    nActive     = active;
    nSingleShot = singleShot;
    nSelfRx     = selfRx;
    nBufFree    = bufFree;
    nComplete   = complete;
    irqSet      = 1'b0;

    if (cmd.request) nComplete = 1'b0;
    if (cmd.request && bufFree) begin
      nPending    = 1'b1;
      nBufFree    = 1'b0;
      nSingleShot = cmd.singleShot;
      nSelfRx     = cmd.selfRx;
    end

    if (pending && txStarted) begin
      nPending = 1'b0;
      nActive  = 1'b1;
      if (cmd.abort) nSingleShot = 1'b1;
    end else if (pending && cmd.abort) begin
      nPending = 1'b0;
      nBufFree = 1'b1;
      irqSet   = 1'b1;
    end

    if (active) begin
      if (cmd.abort) nSingleShot = 1'b1;
      if (txDone) begin
        nActive   = 1'b0;
        nComplete = 1'b1;
        nBufFree  = 1'b1;
        irqSet    = 1'b1;
      end else if (txFail || txArbLost) begin
        nActive = 1'b0;
        if (singleShot || cmd.abort) begin
          nBufFree = 1'b1;
          irqSet   = 1'b1;
        end else begin
          nPending = 1'b1;
        end
      end
    end

    if (irqSet)           nIrq = 1'b1;
    else if (irqRdStrobe) nIrq = 1'b0;
    else                  nIrq = irq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending    <= 1'b0;
      active     <= 1'b0;
      singleShot <= 1'b0;
      selfRx     <= 1'b0;
      bufFree    <= 1'b1;
      complete   <= 1'b1;
      irq        <= 1'b0;
    end else begin
      pending    <= nPending;
      active     <= nActive;
      singleShot <= nSingleShot;
      selfRx     <= nSelfRx;
      bufFree    <= nBufFree;
      complete   <= nComplete;
      irq        <= nIrq;
    end
  end

  assign txStartReq   = pending;
  assign txSingleShot = singleShot;
  assign txSelfRx     = selfRx;
  assign txBufFree    = bufFree;
  assign txComplete   = complete;
  assign txActive     = active;
  assign txIrq        = irq;
  assign bufCtl.wrEn  = bufWr && bufFree;

  // R10
  lock_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pending && bufFree) && !(pending && active));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.request && bufFree) |=> (txStartReq && !txBufFree && !txComplete));

  // R5
  start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending && txStarted) |=> (txActive && !txStartReq));

  // R6
  abort_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !txStarted && cmd.abort) |=> (!txStartReq && txBufFree && txIrq));

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && txDone) |=> (txBufFree && txComplete && txIrq && !txActive));

  // R9
  retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !txDone && (txFail || txArbLost) && !singleShot && !cmd.abort)
      |=> (txStartReq && !txBufFree));

  // R12
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txIrq && !irqRdStrobe) |=> txIrq);
endmodule

// File: rtl/can_txc_buf.sv
module can_txc_buf
  import can_txc_pkg::*;
#(
  parameter int DEPTH  = 13,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        ctl,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   mem[i] <= '0;
      else if (ctl.wrEn && wrAddr == ADDR_W'(i))   mem[i] <= wrData;
    end

    // R10
    entry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(ctl.wrEn && wrAddr == ADDR_W'(i)) |=> $stable(mem[i]));
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rdAddr == ADDR_W'(i)) rdData = mem[i];
  end
endmodule

// File: rtl/can_tx_cmd_ctrl.sv
module can_tx_cmd_ctrl
  import can_txc_pkg::*;
#(
  parameter  int BUF_BYTES = 13,
  parameter  int DATA_W    = 8,
  localparam int ADDR_W    = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic [CMD_W-1:0]  cmdData,
  output logic [CMD_W-1:0]  cmdRdData,
  input  logic              bufWr,
  input  logic [ADDR_W-1:0] bufWrAddr,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic [ADDR_W-1:0] bufRdAddr,
  output logic [DATA_W-1:0] bufRdData,
  output logic              txStartReq,
  output logic              txSingleShot,
  output logic              txSelfRx,
  input  logic              txStarted,
  input  logic              txDone,
  input  logic              txFail,
  input  logic              txArbLost,
  output logic              txBufFree,
  output logic              txComplete,
  output logic              txActive,
  output logic              txIrq,
  input  logic              irqRdStrobe
);
  cmdStrobe_t cmdStb;
  bufStrobe_t bufStb;

  // R1: the command byte is write-only
  assign cmdRdData = '0;

  can_txc_decode uDecode (
    .clk     (clk),
    .rstN    (rstN),
    .cmdWr   (cmdWr),
    .cmdData (cmdData),
    .strobes (cmdStb)
  );

  can_txc_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmdStb),
    .txStarted    (txStarted),
    .txDone       (txDone),
    .txFail       (txFail),
    .txArbLost    (txArbLost),
    .irqRdStrobe  (irqRdStrobe),
    .bufWr        (bufWr),
    .txStartReq   (txStartReq),
    .txSingleShot (txSingleShot),
    .txSelfRx     (txSelfRx),
    .txBufFree    (txBufFree),
    .txComplete   (txComplete),
    .txActive     (txActive),
    .txIrq        (txIrq),
    .bufCtl       (bufStb)
  );

  can_txc_buf #(.DEPTH(BUF_BYTES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uBuf (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (bufStb),
    .wrAddr (bufWrAddr),
    .wrData (bufWrData),
    .rdAddr (bufRdAddr),
    .rdData (bufRdData)
  );
endmodule

// File: tb/tb_can_tx_cmd_ctrl.sv
module tb_can_tx_cmd_ctrl;
  localparam int BUF_BYTES = 13;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = $clog2(BUF_BYTES);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWr = 1'b0;
  logic [7:0] cmdData = '0;
  logic [7:0] cmdRdData;
  logic bufWr = 1'b0;
  logic [ADDR_W-1:0] bufWrAddr = '0;
  logic [DATA_W-1:0] bufWrData = '0;
  logic [ADDR_W-1:0] bufRdAddr = '0;
  logic [DATA_W-1:0] bufRdData;
  logic txStartReq, txSingleShot, txSelfRx, txBufFree, txComplete, txActive, txIrq;
  logic txStarted = 1'b0, txDone = 1'b0, txFail = 1'b0, txArbLost = 1'b0;
  logic irqRdStrobe = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  can_tx_cmd_ctrl #(.BUF_BYTES(BUF_BYTES), .DATA_W(DATA_W)) dut (.*);

  // reference model: 0 = buffer free, 1 = queued, 2 = on the bus
  int mState = 0;
  bit mSingle = 0, mSelf = 0, mTcs = 1, mIrq = 0, mPrevWr = 0;
  int mMem [BUF_BYTES];

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mSingle = 0; mSelf = 0; mTcs = 1; mIrq = 0; mPrevWr = 0;
      foreach (mMem[i]) mMem[i] = 0;
    end else begin
      bit live, isReq, isAbort, setIrq;
      live    = cmdWr && !mPrevWr;
      isReq   = live && (cmdData[0] || cmdData[4]);
      isAbort = live && cmdData[1] && !isReq;
      setIrq  = 0;
      if (bufWr && mState == 0 && int'(bufWrAddr) < BUF_BYTES)
        mMem[bufWrAddr] = int'(bufWrData);
      if (isReq) mTcs = 0;
      case (mState)
        0: if (isReq) begin
             mState = 1; mSingle = cmdData[1]; mSelf = cmdData[4] && !cmdData[0];
           end
        1: if (txStarted) begin
             mState = 2; if (isAbort) mSingle = 1;
           end else if (isAbort) begin
             mState = 0; setIrq = 1;
           end
        default: begin
          if (isAbort) mSingle = 1;
          if (txDone) begin
            mState = 0; mTcs = 1; setIrq = 1;
          end else if (txFail || txArbLost) begin
            if (mSingle) begin mState = 0; setIrq = 1; end
            else mState = 1;
          end
        end
      endcase
      if (setIrq) mIrq = 1;
      else if (irqRdStrobe) mIrq = 0;
      mPrevWr = cmdWr;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      chk("R1 cmdRdData", int'(cmdRdData), 0);
      chk("R2 txStartReq", int'(txStartReq), int'(mState == 1));
      chk("R3 txSingleShot", int'(txSingleShot), int'(mSingle));
      chk("R4 txSelfRx", int'(txSelfRx), int'(mSelf));
      chk("R5 txActive", int'(txActive), int'(mState == 2));
      chk("R10 txBufFree", int'(txBufFree), int'(mState == 0));
      chk("R8 txComplete", int'(txComplete), int'(mTcs));
      chk("R12 txIrq", int'(txIrq), int'(mIrq));
      chk("R10 bufRdData", int'(bufRdData),
          int'(bufRdAddr) < BUF_BYTES ? mMem[bufRdAddr] : 0);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic cmd(input logic [7:0] v);
    cmdWr = 1'b1; cmdData = v; step(); cmdWr = 1'b0; cmdData = '0; step();
  endtask

  // 0 started, 1 done, 2 fail, 3 arbitration lost
  task automatic eng(input int code);
    txStarted = (code == 0); txDone = (code == 1);
    txFail = (code == 2); txArbLost = (code == 3);
    step();
    txStarted = 0; txDone = 0; txFail = 0; txArbLost = 0;
  endtask

  task automatic irqRead();
    irqRdStrobe = 1'b1; step(); irqRdStrobe = 1'b0;
  endtask

  task automatic bwrite(input int a, input int d);
    bufWr = 1'b1; bufWrAddr = ADDR_W'(a); bufWrData = DATA_W'(d); step(); bufWr = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    step();
    // R8 reset state
    chk("R8 reset free", int'(txBufFree), 1);
    chk("R8 reset complete", int'(txComplete), 1);
    chk("R8 reset irq", int'(txIrq), 0);

    // R10 write while free, then locked write discarded
    bwrite(3, 8'hA5);
    bufRdAddr = 3;
    cmd(8'h01);
    chk("R2 request accepted", int'(txStartReq), 1);
    chk("R2 complete cleared", int'(txComplete), 0);
    bwrite(3, 8'hFF);
    chk("R10 locked write dropped", int'(bufRdData), 8'hA5);
    // R2 request while locked does not touch qualifiers
    cmd(8'h11);
    chk("R2 locked request ignored", int'(txSelfRx), 0);
    eng(0);
    chk("R5 started", int'(txActive), 1);
    eng(1);
    chk("R8 done complete", int'(txComplete), 1);
    chk("R8 done irq", int'(txIrq), 1);
    irqRead();
    chk("R12 irq cleared", int'(txIrq), 0);

    // R2 self-reception alone, R9 retries
    cmd(8'h10);
    chk("R2 self-rx request", int'(txSelfRx), 1);
    eng(0); eng(2);
    chk("R9 retry after error", int'(txStartReq), 1);
    eng(0); eng(3);
    chk("R9 retry after arbitration", int'(txStartReq), 1);
    eng(0); eng(1);

    // R3 single-shot release
    irqRead();
    cmd(8'h03);
    chk("R3 single shot", int'(txSingleShot), 1);
    eng(0); eng(2);
    chk("R9 single-shot release", int'(txBufFree), 1);
    chk("R9 complete stays 0", int'(txComplete), 0);
    chk("R9 irq", int'(txIrq), 1);
    irqRead();

    // R3 self + abort, then R6 cancel
    cmd(8'h12);
    chk("R3 self single", int'(txSelfRx) + 2 * int'(txSingleShot), 3);
    cmd(8'h02);
    chk("R6 cancelled", int'(txStartReq), 0);
    chk("R6 freed", int'(txBufFree), 1);
    chk("R6 irq", int'(txIrq), 1);
    chk("R6 complete 0", int'(txComplete), 0);
    irqRead();

    // R3 all three bits
    cmd(8'h13);
    chk("R3 all three selfRx", int'(txSelfRx), 0);
    chk("R3 all three single", int'(txSingleShot), 1);
    cmd(8'h02);

    // R4 request + self, R13 no-effect commands, R7 abort while active
    cmd(8'h11);
    chk("R4 self dropped", int'(txSelfRx), 0);
    chk("R4 not single", int'(txSingleShot), 0);
    cmd(8'h00);
    chk("R13 zero write keeps request", int'(txStartReq), 1);
    cmd(8'h0C);
    cmd(8'hE0);
    chk("R13 other bits ignored", int'(txStartReq), 1);
    eng(0);
    cmd(8'h02);
    chk("R7 frame continues", int'(txActive), 1);
    eng(2);
    chk("R7 no retry", int'(txStartReq), 0);
    chk("R7 released", int'(txBufFree), 1);
    irqRead();

    // R11 back-to-back command writes
    cmdWr = 1'b1; cmdData = 8'h01; step();
    cmdData = 8'h02; step();
    cmdWr = 1'b0; cmdData = '0; step();
    chk("R11 second write ignored", int'(txStartReq), 1);
    // abort in the same cycle as start: frame goes out single-shot
    cmdWr = 1'b1; cmdData = 8'h02; txStarted = 1'b1; step();
    cmdWr = 1'b0; cmdData = '0; txStarted = 1'b0; step();
    chk("R7 start beats abort", int'(txActive), 1);
    chk("R7 becomes single shot", int'(txSingleShot), 1);
    // R12 set wins over read strobe
    txDone = 1'b1; irqRdStrobe = 1'b1; step();
    txDone = 1'b0; irqRdStrobe = 1'b0;
    chk("R12 set beats clear", int'(txIrq), 1);
    irqRead();

    // R10 out-of-range addresses
    bwrite(14, 8'h5A);
    bufRdAddr = 14; step();
    chk("R10 out of range read", int'(bufRdData), 0);
    bwrite(12, 8'h3C);
    bufRdAddr = 12; step();
    chk("R10 last entry", int'(bufRdData), 8'h3C);
    chk("R1 read zero", int'(cmdRdData), 0);

    repeat (3) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule